// File: doc/BRIEF.md
# Tear-Free 64-bit Read Event Counter Pair

This block keeps two free-running event counters for a cache pipeline. One counts every read transaction; the other counts only the reads that hit. Each event input is a single-cycle pulse. A hit pulse is counted only when a read pulse arrives in the same cycle. Each counter is `2*WORD_W` bits wide, which is 64 bits with the default `WORD_W` of 32.

Software reaches each counter through a 32-bit CSR read port, one register for the lower half and one for the upper half. Reading the lower half copies the upper half of the same counter value into a per-counter holding register. A later read of the upper half returns that copy, so the two halves always belong to one instant in time. The same read releases the hold. The live counter never stops counting while a hold is active.

A read request is an address plus a strobe. Its data appears on the output one cycle later.

Top module: `evt_cnt_snap`

## Requirements
- R1: After reset both counters are zero, no hold is active, and reads of all four registers return zero.
- R2: The read counter adds one on every clock cycle in which `rd_evt_i` is high.
- R3: The hit counter adds one only in cycles where both `hit_evt_i` and `rd_evt_i` are high. A hit pulse without a read pulse leaves it unchanged.
- R4: Read data appears on `csr_rdata_o` in the cycle after the strobe. The output is zero in any cycle after a cycle with no strobe, and zero after a strobe to an unmapped address.
- R5: Reading a lower-half register returns the lower `WORD_W` bits of the counter value before that cycle's increment. The same read captures the matching upper bits into that counter's hold register.
- R6: Reading an upper-half register while its hold is active returns the held bits and clears the hold.
- R7: While a hold is active the live counter keeps counting. Once the hold is released, an upper-half read returns the live upper bits.
- R8: The two counters have separate hold registers and hold flags. Reading one counter's registers never changes the other's hold.
- R9: A counter at the all-ones value wraps to zero on its next event and does not saturate.
- R10: A second lower-half read made without an upper-half read in between recaptures the upper bits.
- R11: The register offsets are 0x1C for the read counter's upper half, 0x20 for its lower half, 0x24 for the hit counter's upper half and 0x28 for its lower half. Every other address is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_evt_i | input | 1 | Read transaction pulse |
| hit_evt_i | input | 1 | Read hit pulse, qualified by `rd_evt_i` |
| csr_rd_i | input | 1 | CSR read strobe |
| csr_addr_i | input | ADDR_W | CSR read address |
| csr_rdata_o | output | WORD_W | CSR read data, valid the cycle after the strobe |

## Verification
The assertions assume one address per read strobe and single-cycle event pulses. They also assume `hit_evt_i` may arrive without `rd_evt_i`, and the design must then ignore it. The random stimulus therefore drives the hit input freely, including cycles without a read pulse. It mixes mapped and unmapped addresses and back-to-back reads. The bench shrinks `WORD_W` to 4 so the counters wrap within a few hundred events, which makes carries across the two halves and full wraparound reachable. Directed runs cover reads taken across a carry, repeated lower-half reads, and interleaving between the two counters.

// File: rtl/evt_cnt_snap.sv
module evt_cnt_snap #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] RD_HI_ADDR  = 8'h1C,
  parameter logic [ADDR_W-1:0] RD_LO_ADDR  = 8'h20,
  parameter logic [ADDR_W-1:0] HIT_HI_ADDR = 8'h24,
  parameter logic [ADDR_W-1:0] HIT_LO_ADDR = 8'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_evt_i,
  input  logic              hit_evt_i,
  input  logic              csr_rd_i,
  input  logic [ADDR_W-1:0] csr_addr_i,
  output logic [WORD_W-1:0] csr_rdata_o
);

  localparam int CNT_W = 2 * WORD_W;
  localparam int NCNT  = 2;
  localparam logic [ADDR_W-1:0] HI_ADDR [NCNT] = '{RD_HI_ADDR, HIT_HI_ADDR};
  localparam logic [ADDR_W-1:0] LO_ADDR [NCNT] = '{RD_LO_ADDR, HIT_LO_ADDR};

  logic [CNT_W-1:0]  cnt_q  [NCNT];
  logic [WORD_W-1:0] hold_q [NCNT];
  logic [NCNT-1:0]   held_q;
  logic [NCNT-1:0]   inc;
  logic [NCNT-1:0]   lo_sel;
  logic [NCNT-1:0]   hi_sel;
  logic [WORD_W-1:0] rdata_d;

  assign inc[0] = rd_evt_i;
  assign inc[1] = rd_evt_i & hit_evt_i;

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    assign lo_sel[k] = csr_rd_i && (csr_addr_i == LO_ADDR[k]);
    assign hi_sel[k] = csr_rd_i && (csr_addr_i == HI_ADDR[k]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[k]  <= '0;
        hold_q[k] <= '0;
        held_q[k] <= 1'b0;
      end else begin
        if (inc[k]) cnt_q[k] <= cnt_q[k] + 1'b1;
        if (lo_sel[k]) begin
          hold_q[k] <= cnt_q[k][CNT_W-1:WORD_W];
          held_q[k] <= 1'b1;
        end else if (hi_sel[k]) begin
          held_q[k] <= 1'b0;
        end
      end
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      inc[k] |=> cnt_q[k] == CNT_W'($past(cnt_q[k]) + 1'b1));
    p_idle_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !inc[k] |=> $stable(cnt_q[k]));
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lo_sel[k] |=> held_q[k] && hold_q[k] == $past(cnt_q[k][CNT_W-1:WORD_W]));
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hi_sel[k] |=> !held_q[k]);
    p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_sel[k] |=> $stable(hold_q[k]));
  end

  p_hit_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt_i && !rd_evt_i) |=> $stable(cnt_q[1]));

  always_comb begin
    rdata_d = '0;
    for (int k = 0; k < NCNT; k++) begin
      if (lo_sel[k]) rdata_d = cnt_q[k][WORD_W-1:0];
      if (hi_sel[k]) rdata_d = held_q[k] ? hold_q[k] : cnt_q[k][CNT_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csr_rdata_o <= '0;
    else        csr_rdata_o <= rdata_d;
  end

  p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd_i |=> csr_rdata_o == '0);

endmodule

// File: tb/evt_cnt_snap_bench.sv
module evt_cnt_snap_bench;
  localparam int W = 4;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_RH = 8'h1C, A_RL = 8'h20, A_HH = 8'h24, A_HL = 8'h28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_evt = 1'b0, hit_evt = 1'b0, csr_rd = 1'b0;
  logic [AW-1:0] csr_addr = '0;
  logic [W-1:0] rdata;

  always #5 clk = ~clk;

  evt_cnt_snap #(.WORD_W(W), .ADDR_W(AW)) u_evt_cnt_snap (
    .clk(clk), .rst_n(rst_n), .rd_evt_i(rd_evt), .hit_evt_i(hit_evt),
    .csr_rd_i(csr_rd), .csr_addr_i(csr_addr), .csr_rdata_o(rdata));

  int n_vec = 0, n_bad = 0;
  logic [2*W-1:0] m_cnt [2];
  logic [W-1:0]   m_hold [2];
  logic [1:0]     m_held;

  function automatic logic [W-1:0] exp_read(input logic rd, input logic [AW-1:0] a);
    if (!rd) return '0;
    case (a)
      A_RL: return m_cnt[0][W-1:0];
      A_HL: return m_cnt[1][W-1:0];
      A_RH: return m_held[0] ? m_hold[0] : m_cnt[0][2*W-1:W];
      A_HH: return m_held[1] ? m_hold[1] : m_cnt[1][2*W-1:W];
      default: return '0;
    endcase
  endfunction

  task automatic model_step(input logic r, input logic h, input logic rd, input logic [AW-1:0] a);
    for (int k = 0; k < 2; k++) begin
      if (rd && a == (k == 0 ? A_RL : A_HL)) begin
        m_hold[k] = m_cnt[k][2*W-1:W];
        m_held[k] = 1'b1;
      end else if (rd && a == (k == 0 ? A_RH : A_HH)) begin
        m_held[k] = 1'b0;
      end
    end
    if (r) m_cnt[0] = m_cnt[0] + 1'b1;
    if (r && h) m_cnt[1] = m_cnt[1] + 1'b1;
  endtask

  task automatic cyc(input logic r, input logic h, input logic rd,
                     input logic [AW-1:0] a, input string tag);
    logic [W-1:0] e;
    @(negedge clk);
    rd_evt = r; hit_evt = h; csr_rd = rd; csr_addr = a;
    e = exp_read(rd, a);
    model_step(r, h, rd, a);
    @(posedge clk); #1;
    n_vec++;
    if (rdata !== e) begin
      n_bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rdata, e);
    end
  endtask

  task automatic events(input int n, input logic h);
    for (int i = 0; i < n; i++) cyc(1'b1, h, 1'b0, '0, "R2");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    m_cnt[0] = '0; m_cnt[1] = '0; m_hold[0] = '0; m_hold[1] = '0; m_held = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state via all four registers, R11 offsets
    cyc(0, 0, 1, A_RL, "R1"); cyc(0, 0, 1, A_RH, "R1");
    cyc(0, 0, 1, A_HL, "R1"); cyc(0, 0, 1, A_HH, "R1");
    // R2 / R3 basic counting, hit without read ignored
    events(5, 1'b1);
    cyc(0, 1, 0, '0, "R3"); cyc(0, 1, 0, '0, "R3");
    cyc(0, 0, 1, A_RL, "R2"); cyc(0, 0, 1, A_RH, "R6");
    cyc(0, 0, 1, A_HL, "R3"); cyc(0, 0, 1, A_HH, "R3");
    // R4 unmapped address and idle
    cyc(1, 0, 1, 8'h2C, "R4"); cyc(0, 0, 1, 8'h00, "R4"); cyc(0, 0, 0, A_RL, "R4");
    // R7 hold across a carry, live count continues
    events(9, 1'b0);
    cyc(0, 0, 1, A_RL, "R5");
    events(20, 1'b0);
    cyc(0, 0, 1, A_RH, "R6"); cyc(0, 0, 1, A_RH, "R7"); cyc(0, 0, 1, A_RL, "R7");
    // R10 double low read
    cyc(0, 0, 1, A_RL, "R5"); events(17, 1'b0);
    cyc(0, 0, 1, A_RL, "R10"); cyc(0, 0, 1, A_RH, "R10");
    // R8 independent holds
    cyc(0, 0, 1, A_HL, "R8"); events(16, 1'b1);
    cyc(0, 0, 1, A_RL, "R8"); cyc(0, 0, 1, A_RH, "R8"); cyc(0, 0, 1, A_HH, "R8");
    // R9 wraparound
    events(300, 1'b1);
    cyc(0, 0, 1, A_RL, "R9"); cyc(0, 0, 1, A_RH, "R9");
    cyc(0, 0, 1, A_HL, "R9"); cyc(0, 0, 1, A_HH, "R9");
    // random mix
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] s;
      logic [AW-1:0] a;
      s = 3'($urandom % 5);
      case (s)
        0: a = A_RH; 1: a = A_RL; 2: a = A_HH; 3: a = A_HL; default: a = 8'h2C;
      endcase
      cyc(1'($urandom % 4 != 0), 1'($urandom % 2), 1'($urandom % 3 == 0), a, "R4");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule